// File: doc/BRIEF.md
# E1 Frame-Slip Elastic Store

This block moves a 2.048 Mbit/s E1 bit stream from the clock recovered with the data onto a separate reference clock. The write side packs serial bits into bytes and stores them in a buffer that holds two 32-slot frames. The read side serializes the bytes again, one bit per reference clock. The two clocks may differ in frequency. When the buffer drifts towards overflow or underflow, the read side either skips or replays exactly one whole frame. Output frames therefore always start on slot 0 and keep their time-slot order.

In normal operation an external framer marks the first bit of a frame with a strobe, and writing starts from that bit. The read side starts once one full frame has been stored, so it trails the writer by one frame. A static test mode ignores the strobe and packs from the first clock after reset, which suits unframed traffic. Slip decisions are made only when the read side reaches a frame boundary. Each slip gives a one-cycle pulse and sets a sticky flag for its direction. The flags clear only on reset.

Top module: `e1_slip_buffer`

## Requirements
- R1: While either reset is asserted, rd_data, rd_fsync, slip_pulse, slip_deleted and slip_repeated are all 0.
- R2: With test_mode low, input bits are discarded until the first wr_fsync. The bit that arrives with that strobe is the most significant bit of slot 0. Bits are packed most significant first into 8-bit slots. Later strobes have no effect.
- R3: With test_mode high, packing starts with the first wr_clk edge after reset, and wr_fsync is ignored throughout.
- R4: rd_data stays 0 until at least 32 bytes have been stored. After that it emits the stored bytes in write order, most significant bit first, one bit per rd_clk, starting at slot 0.
- R5: rd_fsync is high exactly on the first bit (slot 0, most significant bit) of every output frame, and low on every other bit.
- R6: At a read frame boundary, the fill is the number of stored bytes minus the index of the next byte to read. If the fill exceeds 58, the next 32 bytes are skipped. slip_pulse is then high for one rd_clk, together with the first bit of the new frame, and slip_deleted goes high and stays high.
- R7: At a read frame boundary with a fill below 6, the read index steps back 32 bytes so that the previous frame is output again. slip_pulse is then high for one rd_clk, together with the first bit of the replayed frame, and slip_repeated goes high and stays high.
- R8: Every output frame is one complete stored frame. Consecutive output frames are consecutive stored frames, except that one frame is dropped at a delete and one frame is repeated at a repeat.
- R9: The write count reaches the read domain as a Gray code through a two-stage synchronizer. It changes by at most one bit per read clock, and reading starts when the fill reaches between 31 and 35 bytes.
- R10: No slip occurs while the boundary fill stays within 6 to 58. This tolerates 26 slots of wander in either direction around the nominal one-frame distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| test_mode | input | 1 | Static: 1 selects the free-running mode that ignores framing |
| wr_data | input | 1 | Serial input data |
| wr_fsync | input | 1 | Framer strobe marking the first bit of a frame |
| rd_clk | input | 1 | Reference read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_data | output | 1 | Serial output data, synchronous to rd_clk |
| rd_fsync | output | 1 | High on the first bit of each output frame |
| slip_pulse | output | 1 | One-cycle pulse on the first bit after a slip |
| slip_deleted | output | 1 | Sticky: a frame has been deleted |
| slip_repeated | output | 1 | Sticky: a frame has been repeated |

## Verification
A wrong packing phase or a wrong read index shows up at once as a wrong rd_data bit within one byte time, because each slot carries a value unique to its frame and position. A slip taken with the wrong sign or the wrong distance replays or drops the wrong bytes, and the comparison catches this on the first bit of the following frame. A wrong threshold shows as a slip pulse, or its absence, at the frame boundary where the fill crosses 58 or 6; the reference allows a few bytes of synchronizer lag around each threshold. Runs with a faster writer, a slower writer, matched clocks and the test mode force both slip directions, the quiet case and the unframed start.

// File: rtl/e1es_pkg.sv
`timescale 1ns/1ps
package e1es_pkg;
   typedef enum logic [1:0] {
      SLIP_NONE   = 2'd0,
      SLIP_DELETE = 2'd1,
      SLIP_REPEAT = 2'd2
   } slip_e;
endpackage

// File: rtl/e1es_wr_side.sv
`timescale 1ns/1ps
module e1es_wr_side #(
   parameter int SLOTS  = 32,
   parameter int BITS   = 8,
   parameter int FRAMES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 test_mode,
   input  logic                                 din,
   input  logic                                 fsync,
   input  logic [$clog2(SLOTS*FRAMES)-1:0]      rd_addr,
   output logic [BITS-1:0]                      rd_byte,
   output logic [$clog2(SLOTS*FRAMES):0]        wptr_gray
);
   localparam int DEPTH = SLOTS * FRAMES;
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 1;
   localparam int BCW   = $clog2(BITS);
   localparam logic [BCW-1:0] BLAST = BCW'(BITS - 1);

   logic              aligned;
   logic [BCW-1:0]    bcnt;
   logic [BITS-2:0]   sh;
   logic [PW-1:0]     wptr;
   logic [BITS-1:0]   mem [DEPTH];
   logic              go;
   logic              byte_done;

   // capture runs once aligned, always in test mode, or from the strobe bit
   assign go        = aligned | test_mode | fsync;
   assign byte_done = go && (bcnt == BLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned   <= 1'b0;
         bcnt      <= '0;
         sh        <= '0;
         wptr      <= '0;
         wptr_gray <= '0;
      end else begin
         wptr_gray <= wptr ^ (wptr >> 1);
         if (go) begin
            aligned <= 1'b1;
            sh      <= {sh[BITS-3:0], din};
            if (byte_done) begin
               bcnt <= '0;
               wptr <= wptr + 1'b1;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (byte_done) mem[wptr[AW-1:0]] <= {sh, din};
   end

   assign rd_byte = mem[rd_addr];

   // R2
   wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr != $past(wptr)) |-> (wptr == PW'($past(wptr) + 1'b1)));

   // R3
   test_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> aligned);
endmodule

// File: rtl/e1es_gray_sync.sv
`timescale 1ns/1ps
module e1es_gray_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_gray,
   output logic [W-1:0] q_bin
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st[s] <= '0;
         else if (s == 0) st[s] <= d_gray;
         else             st[s] <= st[(s == 0) ? 0 : s - 1];
      end
   end

   always_comb begin
      q_bin[W-1] = st[STAGES-1][W-1];
      for (int i = W - 2; i >= 0; i--) q_bin[i] = q_bin[i+1] ^ st[STAGES-1][i];
   end

   // R9
   gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st[STAGES-1] ^ $past(st[STAGES-1])) <= 1);
endmodule

// File: rtl/e1es_rd_side.sv
`timescale 1ns/1ps
module e1es_rd_side
   import e1es_pkg::*;
#(
   parameter int SLOTS       = 32,
   parameter int BITS        = 8,
   parameter int FRAMES      = 2,
   parameter int SLIP_MARGIN = 6
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [$clog2(SLOTS*FRAMES):0]        wbin,
   output logic [$clog2(SLOTS*FRAMES)-1:0]      rd_addr,
   input  logic [BITS-1:0]                      rd_byte,
   output logic                                 dout,
   output logic                                 fsync_o,
   output logic                                 slip_o,
   output logic                                 del_o,
   output logic                                 rep_o
);
   localparam int DEPTH = SLOTS * FRAMES;
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 1;
   localparam int BCW   = $clog2(BITS);
   localparam int SW    = $clog2(SLOTS);
   localparam logic [BCW-1:0] BLAST   = BCW'(BITS - 1);
   localparam logic [PW-1:0]  SLOTS_P = PW'(SLOTS);
   localparam logic [PW-1:0]  HI_P    = PW'(DEPTH - SLIP_MARGIN);
   localparam logic [PW-1:0]  LO_P    = PW'(SLIP_MARGIN);
   localparam logic [PW-1:0]  FWD_P   = PW'(SLOTS + 1);
   localparam logic [PW-1:0]  BACK_P  = PW'(1 - SLOTS);

   logic            run;
   logic [BCW-1:0]  bcnt;
   logic [PW-1:0]   rptr;
   logic [BITS-1:0] sh;
   logic [PW-1:0]   rptr_inc, fill_inc, rptr_nx;
   logic            start, byte_end, frame_end;
   slip_e           kind;

   assign start     = !run && (wbin >= SLOTS_P);
   assign byte_end  = run && (bcnt == BLAST);
   assign frame_end = byte_end && (rptr[SW-1:0] == {SW{1'b1}});
   assign rptr_inc  = rptr + 1'b1;
   assign fill_inc  = wbin - rptr_inc;

   always_comb begin
      kind = SLIP_NONE;
      if (frame_end && (fill_inc > HI_P))      kind = SLIP_DELETE;
      else if (frame_end && (fill_inc < LO_P)) kind = SLIP_REPEAT;
      case (kind)
         SLIP_DELETE: rptr_nx = rptr_inc + SLOTS_P;
         SLIP_REPEAT: rptr_nx = rptr_inc - SLOTS_P;
         default:     rptr_nx = rptr_inc;
      endcase
   end

   assign rd_addr = start ? '0 : rptr_nx[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         bcnt   <= '0;
         rptr   <= '0;
         sh     <= '0;
         slip_o <= 1'b0;
         del_o  <= 1'b0;
         rep_o  <= 1'b0;
      end else begin
         slip_o <= (kind != SLIP_NONE);
         del_o  <= del_o | (kind == SLIP_DELETE);
         rep_o  <= rep_o | (kind == SLIP_REPEAT);
         if (start) begin
            run  <= 1'b1;
            rptr <= '0;
            bcnt <= '0;
            sh   <= rd_byte;
         end else if (byte_end) begin
            rptr <= rptr_nx;
            bcnt <= '0;
            sh   <= rd_byte;
         end else if (run) begin
            bcnt <= bcnt + 1'b1;
            sh   <= sh << 1;
         end
      end
   end

   assign dout    = run & sh[BITS-1];
   assign fsync_o = run && (bcnt == '0) && (rptr[SW-1:0] == '0);

   // R6
   slip_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip_o |-> fsync_o);

   // R8
   rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && (rptr != $past(rptr))) |->
         ((PW'(rptr - $past(rptr)) == PW'(1)) ||
          (PW'(rptr - $past(rptr)) == FWD_P) ||
          (PW'(rptr - $past(rptr)) == BACK_P)));

   // R6
   del_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(del_o) |-> slip_o);

   // R7
   rep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rep_o) |-> slip_o);
endmodule

// File: rtl/e1_slip_buffer.sv
`timescale 1ns/1ps
module e1_slip_buffer #(
   parameter int SLOTS       = 32,
   parameter int BITS        = 8,
   parameter int FRAMES      = 2,
   parameter int SLIP_MARGIN = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic wr_clk,
   input  logic wr_rst_n,
   input  logic test_mode,
   input  logic wr_data,
   input  logic wr_fsync,
   input  logic rd_clk,
   input  logic rd_rst_n,
   output logic rd_data,
   output logic rd_fsync,
   output logic slip_pulse,
   output logic slip_deleted,
   output logic slip_repeated
);
   localparam int DEPTH = SLOTS * FRAMES;
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 1;

   if ((SLOTS & (SLOTS - 1)) != 0 || SLOTS < 4) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 4");
   end
   if ((BITS & (BITS - 1)) != 0 || BITS < 4) begin : g_bad_bits
      $error("BITS must be a power of two of at least 4");
   end
   if (FRAMES != 2) begin : g_bad_frames
      $error("store depth is fixed at two frames");
   end
   if (SLIP_MARGIN < 1 || SLIP_MARGIN >= SLOTS / 2) begin : g_bad_margin
      $error("SLIP_MARGIN must lie between 1 and SLOTS/2-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are required");
   end

   logic [AW-1:0]   rd_addr;
   logic [BITS-1:0] rd_byte;
   logic [PW-1:0]   wptr_gray;
   logic [PW-1:0]   wbin_rd;

   e1es_wr_side #(.SLOTS(SLOTS), .BITS(BITS), .FRAMES(FRAMES)) i_wr (
      .clk       (wr_clk),
      .rst_n     (wr_rst_n),
      .test_mode (test_mode),
      .din       (wr_data),
      .fsync     (wr_fsync),
      .rd_addr   (rd_addr),
      .rd_byte   (rd_byte),
      .wptr_gray (wptr_gray)
   );

   e1es_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync (
      .clk    (rd_clk),
      .rst_n  (rd_rst_n),
      .d_gray (wptr_gray),
      .q_bin  (wbin_rd)
   );

   e1es_rd_side #(.SLOTS(SLOTS), .BITS(BITS), .FRAMES(FRAMES),
                  .SLIP_MARGIN(SLIP_MARGIN)) i_rd (
      .clk     (rd_clk),
      .rst_n   (rd_rst_n),
      .wbin    (wbin_rd),
      .rd_addr (rd_addr),
      .rd_byte (rd_byte),
      .dout    (rd_data),
      .fsync_o (rd_fsync),
      .slip_o  (slip_pulse),
      .del_o   (slip_deleted),
      .rep_o   (slip_repeated)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge rd_clk)
      !rd_rst_n |-> !(rd_data | rd_fsync | slip_pulse | slip_deleted | slip_repeated));
endmodule

// File: tb/test_e1_slip_buffer.sv
`timescale 1ns/1ps
module test_e1_slip_buffer;
   localparam real CLK_PERIOD = 10.0;
   localparam int  WATCHDOG   = 190000;

   logic wr_clk = 1'b0, rd_clk = 1'b0;
   logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic test_mode = 1'b0, wr_data = 1'b0, wr_fsync = 1'b0;
   logic rd_data, rd_fsync, slip_pulse, slip_deleted, slip_repeated;
   real  wr_half = CLK_PERIOD / 2.0;

   int compared = 0, mismatched = 0;
   bit active = 0, started = 0;
   int wr_bytes = 0, rk = 0, bi = 0, dels = 0, reps = 0, bits_seen = 0;

   always #(wr_half) wr_clk = ~wr_clk;
   always #(CLK_PERIOD / 2.0) rd_clk = ~rd_clk;

   e1_slip_buffer i_e1_slip_buffer (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .test_mode(test_mode),
      .wr_data(wr_data), .wr_fsync(wr_fsync), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .rd_data(rd_data), .rd_fsync(rd_fsync), .slip_pulse(slip_pulse),
      .slip_deleted(slip_deleted), .slip_repeated(slip_repeated));

   function automatic logic [7:0] gen_byte(int k);
      return 8'((k * 29) + (k / 32) * 7 + 90);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model of the read stream, compared on every read clock
   always @(negedge rd_clk) begin
      if (active) begin
         if (!started) begin
            if (rd_fsync) begin
               check(wr_bytes >= 31 && wr_bytes <= 35, "R4 R9 start fill", wr_bytes, 32);
               started = 1; rk = 0; bi = 0; bits_seen = 0;
            end else begin
               check(rd_data == 1'b0 && slip_pulse == 1'b0, "R4 idle output", rd_data, 0);
            end
         end
         if (started) begin
            int  f;
            logic [7:0] eb;
            f = wr_bytes - rk;
            if (bi == 0 && rk % 32 == 0 && bits_seen > 0) begin
               if (f >= 10 && f <= 56)
                  check(slip_pulse == 1'b0, "R10 no slip inside window", slip_pulse, 0);
               else if (f > 61)
                  check(slip_pulse == 1'b1, "R6 delete expected", slip_pulse, 1);
               else if (f < 5)
                  check(slip_pulse == 1'b1, "R7 repeat expected", slip_pulse, 1);
               if (slip_pulse) begin
                  if (f > 32) begin rk += 32; dels++; end
                  else        begin rk -= 32; reps++; end
               end
            end else begin
               check(slip_pulse == 1'b0, "R6 pulse only at frame start", slip_pulse, 0);
            end
            eb = gen_byte(rk);
            check(rd_fsync == (bi == 0 && rk % 32 == 0), "R5 frame strobe",
                  rd_fsync, (bi == 0 && rk % 32 == 0));
            check(rd_data == eb[7-bi], test_mode ? "R3 R8 data" : "R2 R8 data",
                  rd_data, eb[7-bi]);
            check(slip_deleted == (dels > 0), "R6 sticky delete flag", slip_deleted, dels > 0);
            check(slip_repeated == (reps > 0), "R7 sticky repeat flag", slip_repeated, reps > 0);
            bits_seen++;
            bi++;
            if (bi == 8) begin bi = 0; rk++; end
         end
      end
   end

   task automatic run_phase(real half, bit tm, int nbits, int garbage);
      active = 0; wr_rst_n = 0; rd_rst_n = 0; wr_data = 0; wr_fsync = 0;
      test_mode = tm; wr_half = half;
      started = 0; wr_bytes = 0; rk = 0; bi = 0; dels = 0; reps = 0; bits_seen = 0;
      repeat (4) @(posedge rd_clk);
      #1;
      check({rd_data, rd_fsync, slip_pulse, slip_deleted, slip_repeated} == 5'b0,
            "R1 reset outputs", {rd_data, rd_fsync, slip_pulse, slip_deleted, slip_repeated}, 0);
      @(negedge wr_clk);
      wr_rst_n = 1; rd_rst_n = 1; active = 1;
      for (int b = 0; b < garbage + nbits; b++) begin
         int d;
         logic [7:0] gb;
         if (b > 0) @(negedge wr_clk);
         d = b - garbage;
         if (d < 0) begin
            wr_data  = (b % 3 == 0);
            wr_fsync = 1'b0;
         end else begin
            gb       = gen_byte(d / 8);
            wr_data  = gb[7 - d % 8];
            wr_fsync = tm ? (d == 77 || d == 333) : (d % 256 == 0);
            wr_bytes = d / 8;
         end
      end
      @(negedge wr_clk);
      active = 0;
      wr_fsync = 0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge rd_clk);
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // matched clocks, normal mode: no slips
      run_phase(CLK_PERIOD / 2.0, 1'b0, 20000, 13);
      check(started, "R4 output started", started, 1);
      check(dels + reps == 0, "R10 no slip at matched rates", dels + reps, 0);
      // writer 3% fast: fill grows, frames deleted
      run_phase(CLK_PERIOD / 2.0 * 0.97, 1'b0, 26000, 13);
      check(dels >= 1, "R6 delete occurred", dels, 1);
      check(reps == 0, "R6 no repeat when writer fast", reps, 0);
      // writer 3% slow: fill shrinks, frames repeated
      run_phase(CLK_PERIOD / 2.0 * 1.03, 1'b0, 26000, 13);
      check(reps >= 1, "R7 repeat occurred", reps, 1);
      check(dels == 0, "R7 no delete when writer slow", dels, 0);
      // free-running test mode with stray strobes
      run_phase(CLK_PERIOD / 2.0, 1'b1, 5000, 0);
      check(started, "R3 test mode output started", started, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule